// File: doc/BRIEF.md
# Adjustable Precision Time Clock

This block keeps network time as a seconds count and a nanoseconds count. The time advances once on each pulse of a 40 ns reference tick. A fractional accumulator can trim the rate so that a tick occasionally adds one nanosecond more or one less. A one-time step can also move the time forward or back by a chosen offset. A 3-bit phase counter gives finer resolution inside a tick.

Software uses a simple word-wide register bus. Values written to the time registers land in shadow copies. A one-shot command bit in the control register then copies the shadows into the live clock, takes a coherent snapshot of the live clock into the shadows, or steps the live clock by the shadow amounts. The live seconds and nanoseconds also leave the block as plain outputs, for local timestamp logic.

Top module: `ptp_rtc_core`

## Requirements
- R1: After `rstN` is low, the live time, the accumulator, the phase, every shadow field and the control register read back as zero.
- R2: While the enable bit (control bit 1) is 1 and rate adjust is off, each `tickEn` pulse adds exactly 40 to the live nanoseconds. While enable is 0, ticks change nothing.
- R3: When the nanoseconds reach or pass 1,000,000,000 after a tick or a step, 10^9 is removed and the seconds go up by one. When a subtracting step drives them below zero, 10^9 is added and one second is borrowed.
- R4: Register map on `busAddr`: 0 is control, 1 is shadow phase (bits 2:0), 2 is shadow nanoseconds (bits 29:0), 3 is shadow seconds, and 4 is rate (bits 29:0 magnitude, bit 31 direction). The control bits are: 0 software reset, 1 enable, 2 rate adjust enable, 3 load, 4 latch, 5 step direction, 6 step. The command bits 0, 3, 4 and 6 read back as 1 for exactly one cycle after the write and then clear themselves.
- R5: The latch command copies the live seconds, nanoseconds and phase into the shadows in a single edge.
- R6: The load command copies the shadow phase, nanoseconds and seconds into the live clock in a single edge. A tick in that same cycle is not applied.
- R7: The step command adds both shadow seconds and shadow nanoseconds to the live time when step direction is 1, and subtracts both when it is 0.
- R8: With rate adjust enabled and direction 1, each enabled tick adds the magnitude to the 32-bit accumulator. A tick on which the accumulator carries out adds 41 ns.
- R9: With rate adjust enabled and direction 0, each enabled tick subtracts the magnitude from the accumulator. A tick on which the accumulator borrows adds 39 ns.
- R10: With rate adjust disabled, the accumulator holds its value and every enabled tick adds exactly 40 ns, whatever the rate register holds.
- R11: While enabled, the phase is cleared by a tick and otherwise counts up by one per core cycle, stopping at 4. While disabled, it holds its value.
- R12: The software reset command clears the live time, the phase and the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | One-cycle pulse per 40 ns reference period |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word index |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for `busAddr` (combinational) |
| liveSec | output | 32 | Live seconds |
| liveNs | output | 30 | Live nanoseconds |

## Verification
The tick path is driven in several ways: plain enabled ticks, ticks while disabled, a tick that lands exactly on the second boundary, and ticks with a full-scale speed-up trim. These cases separate a clock that counts correctly from one that ignores enable, misses the wrap, or carries early. Steps are applied as an add that ends just below the boundary, an add that crosses it, and a subtract that borrows. These show whether both fields move, whether the direction bit is obeyed, and whether the carry is handled in each direction. A slow-down trim of one unit after a software reset gives 39 ns on the first tick only if the accumulator was really cleared. Phase snapshots taken after a long enabled idle period and one cycle after a tick tell saturation apart from the clear-on-tick behaviour.

// File: rtl/ptp_rtc_pkg.sv
package ptp_rtc_pkg;

  // one-cycle command strobes from the register file to the time datapath
  typedef struct packed {
    logic swReset;
    logic load;
    logic latch;
    logic step;
    logic stepAdd;
  } rtcCmd_t;

  // register word indexes
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_PHASE = 1;
  localparam int ADDR_NS    = 2;
  localparam int ADDR_SEC   = 3;
  localparam int ADDR_RATE  = 4;

  // control bit positions
  localparam int BIT_RESET   = 0;
  localparam int BIT_ENABLE  = 1;
  localparam int BIT_RATE_EN = 2;
  localparam int BIT_LOAD    = 3;
  localparam int BIT_LATCH   = 4;
  localparam int BIT_DIR     = 5;
  localparam int BIT_STEP    = 6;

endpackage

// File: rtl/ptp_rtc_regs.sv
module ptp_rtc_regs
  import ptp_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int PH_W   = 3,
  parameter int RATE_W = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [SEC_W-1:0]  liveSec,
  input  logic [NS_W-1:0]   liveNs,
  input  logic [PH_W-1:0]   livePhase,
  output rtcCmd_t           cmd,
  output logic              enable,
  output logic              rateEn,
  output logic              rateDir,
  output logic [RATE_W-1:0] rateMag,
  output logic [SEC_W-1:0]  shSec,
  output logic [NS_W-1:0]   shNs,
  output logic [PH_W-1:0]   shPhase
);

  logic stepDir;
  logic wrCtrl, wrPhase, wrNs, wrSec, wrRate;

  always_comb begin
    wrCtrl  = busWe && (busAddr == ADDR_W'(ADDR_CTRL));
    wrPhase = busWe && (busAddr == ADDR_W'(ADDR_PHASE));
    wrNs    = busWe && (busAddr == ADDR_W'(ADDR_NS));
    wrSec   = busWe && (busAddr == ADDR_W'(ADDR_SEC));
    wrRate  = busWe && (busAddr == ADDR_W'(ADDR_RATE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmd     <= '0;
      enable  <= 1'b0;
      rateEn  <= 1'b0;
      stepDir <= 1'b0;
      rateDir <= 1'b0;
      rateMag <= '0;
      shSec   <= '0;
      shNs    <= '0;
      shPhase <= '0;
    end else begin
      cmd <= '0;  // command strobes live for one cycle only
      if (wrCtrl) begin
        enable      <= busWdata[BIT_ENABLE];
        rateEn      <= busWdata[BIT_RATE_EN];
        stepDir     <= busWdata[BIT_DIR];
        cmd.swReset <= busWdata[BIT_RESET];
        cmd.load    <= busWdata[BIT_LOAD];
        cmd.latch   <= busWdata[BIT_LATCH];
        cmd.step    <= busWdata[BIT_STEP];
        cmd.stepAdd <= busWdata[BIT_DIR];
      end
      if (wrRate) begin
        rateMag <= busWdata[RATE_W-1:0];
        rateDir <= busWdata[DATA_W-1];
      end
      // a snapshot takes precedence over a bus write in the same cycle
      if (cmd.latch) begin
        shSec   <= liveSec;
        shNs    <= liveNs;
        shPhase <= livePhase;
      end else begin
        if (wrPhase) shPhase <= busWdata[PH_W-1:0];
        if (wrNs)    shNs    <= busWdata[NS_W-1:0];
        if (wrSec)   shSec   <= busWdata[SEC_W-1:0];
      end
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(ADDR_CTRL): begin
        busRdata[BIT_RESET]   = cmd.swReset;
        busRdata[BIT_ENABLE]  = enable;
        busRdata[BIT_RATE_EN] = rateEn;
        busRdata[BIT_LOAD]    = cmd.load;
        busRdata[BIT_LATCH]   = cmd.latch;
        busRdata[BIT_DIR]     = stepDir;
        busRdata[BIT_STEP]    = cmd.step;
      end
      ADDR_W'(ADDR_PHASE): busRdata = DATA_W'(shPhase);
      ADDR_W'(ADDR_NS):    busRdata = DATA_W'(shNs);
      ADDR_W'(ADDR_SEC):   busRdata = DATA_W'(shSec);
      ADDR_W'(ADDR_RATE): begin
        busRdata[RATE_W-1:0] = rateMag;
        busRdata[DATA_W-1]   = rateDir;
      end
      default: busRdata = '0;
    endcase
  end

endmodule

// File: rtl/ptp_rtc_datapath.sv
module ptp_rtc_datapath
  import ptp_rtc_pkg::*;
#(
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int PH_W       = 3,
  parameter int FRAC_W     = 32,
  parameter int RATE_W     = 30,
  parameter int STEP_NS    = 40,
  parameter int PHASE_MAX  = 4,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  rtcCmd_t           cmd,
  input  logic              enable,
  input  logic              rateEn,
  input  logic              rateDir,
  input  logic [RATE_W-1:0] rateMag,
  input  logic [SEC_W-1:0]  shSec,
  input  logic [NS_W-1:0]   shNs,
  input  logic [PH_W-1:0]   shPhase,
  output logic [SEC_W-1:0]  liveSec,
  output logic [NS_W-1:0]   liveNs,
  output logic [PH_W-1:0]   livePhase
);

  localparam int SUM_W = NS_W + 3;
  localparam int FW1   = FRAC_W + 1;
  localparam logic signed [SUM_W-1:0] ONE_SEC = SUM_W'(NS_PER_SEC);
  localparam logic signed [SUM_W-1:0] TWO_SEC = ONE_SEC + ONE_SEC;

  logic [FRAC_W-1:0] acc, accNext;
  logic [FRAC_W:0]   fracUp, fracDn;
  logic              advance;
  logic signed [SUM_W-1:0] incr, stepNs, stepTerm, nsSum, wrapAdj;
  logic [SEC_W-1:0]  secStep, secCarry, secNext;
  logic [NS_W-1:0]   nsNext;
  logic [PH_W-1:0]   phaseNext;

  // per-tick increment with fractional rate trim
  always_comb begin
    advance = tickEn && enable;
    fracUp  = {1'b0, acc} + FW1'(rateMag);
    fracDn  = {1'b0, acc} - FW1'(rateMag);
    accNext = acc;
    incr    = '0;
    if (advance) begin
      incr = SUM_W'(STEP_NS);
      if (rateEn) begin
        if (rateDir) begin
          accNext = fracUp[FRAC_W-1:0];
          if (fracUp[FRAC_W]) incr = SUM_W'(STEP_NS + 1);
        end else begin
          accNext = fracDn[FRAC_W-1:0];
          if (fracDn[FRAC_W]) incr = SUM_W'(STEP_NS - 1);
        end
      end
    end
  end

  // tick and step combined, then one normalisation into [0, 1e9)
  always_comb begin
    stepNs   = $signed({3'b000, shNs});
    stepTerm = '0;
    secStep  = '0;
    if (cmd.step) begin
      stepTerm = cmd.stepAdd ? stepNs : -stepNs;
      secStep  = cmd.stepAdd ? shSec : -shSec;
    end
    nsSum = $signed({3'b000, liveNs}) + incr + stepTerm;
    if (nsSum < 0) begin
      wrapAdj  = ONE_SEC;
      secCarry = '1;
    end else if (nsSum >= TWO_SEC) begin
      wrapAdj  = -TWO_SEC;
      secCarry = SEC_W'(2);
    end else if (nsSum >= ONE_SEC) begin
      wrapAdj  = -ONE_SEC;
      secCarry = SEC_W'(1);
    end else begin
      wrapAdj  = '0;
      secCarry = '0;
    end
    nsNext  = NS_W'(nsSum + wrapAdj);
    secNext = liveSec + secStep + secCarry;
  end

  // sub-tick phase counter
  always_comb begin
    phaseNext = livePhase;
    if (enable) begin
      if (tickEn)                                phaseNext = '0;
      else if (livePhase < PH_W'(PHASE_MAX))     phaseNext = livePhase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveSec   <= '0;
      liveNs    <= '0;
      livePhase <= '0;
      acc       <= '0;
    end else if (cmd.swReset) begin
      liveSec   <= '0;
      liveNs    <= '0;
      livePhase <= '0;
      acc       <= '0;
    end else if (cmd.load) begin
      liveSec   <= shSec;
      liveNs    <= shNs;
      livePhase <= shPhase;
    end else begin
      liveSec   <= secNext;
      liveNs    <= nsNext;
      livePhase <= phaseNext;
      acc       <= accNext;
    end
  end

endmodule

// File: rtl/ptp_rtc_core.sv
module ptp_rtc_core
  import ptp_rtc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int PH_W       = 3,
  parameter int FRAC_W     = 32,
  parameter int RATE_W     = 30,
  parameter int STEP_NS    = 40,
  parameter int PHASE_MAX  = 4,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [SEC_W-1:0]  liveSec,
  output logic [NS_W-1:0]   liveNs
);

  rtcCmd_t           cmd;
  logic              enable, rateEn, rateDir;
  logic [RATE_W-1:0] rateMag;
  logic [SEC_W-1:0]  shSec;
  logic [NS_W-1:0]   shNs;
  logic [PH_W-1:0]   shPhase, livePhase;

  ptp_rtc_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEC_W(SEC_W),
    .NS_W(NS_W), .PH_W(PH_W), .RATE_W(RATE_W)
  ) uRegs (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .liveSec(liveSec), .liveNs(liveNs), .livePhase(livePhase),
    .cmd(cmd), .enable(enable), .rateEn(rateEn), .rateDir(rateDir),
    .rateMag(rateMag), .shSec(shSec), .shNs(shNs), .shPhase(shPhase)
  );

  ptp_rtc_datapath #(
    .SEC_W(SEC_W), .NS_W(NS_W), .PH_W(PH_W), .FRAC_W(FRAC_W),
    .RATE_W(RATE_W), .STEP_NS(STEP_NS), .PHASE_MAX(PHASE_MAX),
    .NS_PER_SEC(NS_PER_SEC)
  ) uPath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmd(cmd),
    .enable(enable), .rateEn(rateEn), .rateDir(rateDir), .rateMag(rateMag),
    .shSec(shSec), .shNs(shNs), .shPhase(shPhase),
    .liveSec(liveSec), .liveNs(liveNs), .livePhase(livePhase)
  );

endmodule

// File: rtl/ptp_rtc_checker.sv
module ptp_rtc_checker
  import ptp_rtc_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int STEP_NS    = 40,
  parameter int NS_PER_SEC = 1000000000
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input rtcCmd_t           cmd,
  input logic              enable,
  input logic              rateEn,
  input logic [SEC_W-1:0]  liveSec,
  input logic [NS_W-1:0]   liveNs,
  input logic [SEC_W-1:0]  shSec,
  input logic [NS_W-1:0]   shNs
);

  logic anyCmd, ctrlWrite;
  always_comb begin
    anyCmd    = cmd.swReset || cmd.load || cmd.latch || cmd.step;
    ctrlWrite = busWe && (busAddr == ADDR_W'(ADDR_CTRL));
  end

  // R4
  cmd_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyCmd && !ctrlWrite |=> !(cmd.swReset || cmd.load || cmd.latch || cmd.step));

  // R12
  swreset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.swReset |=> (liveSec == '0) && (liveNs == '0));

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable && !anyCmd |=> $stable(liveSec) && $stable(liveNs));

  // R2
  plain_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickEn && enable && !rateEn && !anyCmd && (liveNs < NS_W'(NS_PER_SEC - STEP_NS))
    |=> liveNs == $past(liveNs) + NS_W'(STEP_NS));

  // R5
  latch_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.latch |=> (shNs == $past(liveNs)) && (shSec == $past(liveSec)));

  // R3
  ns_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load && (liveNs < NS_W'(NS_PER_SEC)) && (shNs < NS_W'(NS_PER_SEC))
    |=> liveNs < NS_W'(NS_PER_SEC));

endmodule

bind ptp_rtc_core ptp_rtc_checker #(
  .ADDR_W(ADDR_W), .SEC_W(SEC_W), .NS_W(NS_W),
  .STEP_NS(STEP_NS), .NS_PER_SEC(NS_PER_SEC)
) uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWe(busWe), .busAddr(busAddr),
  .cmd(cmd), .enable(enable), .rateEn(rateEn), .liveSec(liveSec),
  .liveNs(liveNs), .shSec(shSec), .shNs(shNs)
);

// File: tb/ptp_rtc_core_test.sv
module ptp_rtc_core_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] liveSec;
  logic [29:0] liveNs;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ptp_rtc_core uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .liveSec(liveSec), .liveNs(liveNs)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic test_reset();
    logic [31:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 reg %0d after reset", a), d, 0);
    end
    check("R1 liveSec after reset", liveSec, 0);
    check("R1 liveNs after reset", liveNs, 0);
  endtask

  task automatic test_plain_tick();
    wr(0, 32'h2);
    ticks(3);
    check("R2 three ticks", liveNs, 120);
    wr(0, 32'h0);
    ticks(2);
    check("R2 ticks while disabled", liveNs, 120);
  endtask

  task automatic test_load();
    logic [31:0] d;
    wr(1, 3);
    wr(2, 999999960);
    wr(3, 5);
    wr(0, 32'h8);
    rd(0, d);
    check("R4 load bit visible for one cycle", d, 32'h8);
    idle(1);
    rd(0, d);
    check("R4 load bit self-cleared", d, 0);
    check("R6 loaded seconds", liveSec, 5);
    check("R6 loaded nanoseconds", liveNs, 999999960);
    wr(0, 32'h10);
    idle(1);
    rd(1, d);
    check("R6 loaded phase, R11 held while disabled", d, 3);
  endtask

  task automatic test_wrap();
    wr(0, 32'h2);
    ticks(1);
    check("R3 tick wraps nanoseconds", liveNs, 0);
    check("R3 tick carries into seconds", liveSec, 6);
    wr(0, 32'h0);
  endtask

  task automatic test_latch();
    logic [31:0] d;
    wr(0, 32'h10);
    idle(1);
    rd(2, d);
    check("R5 latched nanoseconds", d, 0);
    rd(3, d);
    check("R5 latched seconds", d, 6);
  endtask

  task automatic test_step();
    wr(2, 999999990); wr(3, 3); wr(0, 32'h60); idle(1);
    check("R7 step add seconds", liveSec, 9);
    check("R7 step add nanoseconds", liveNs, 999999990);
    wr(2, 20); wr(3, 0); wr(0, 32'h60); idle(1);
    check("R3 step add carry seconds", liveSec, 10);
    check("R3 step add carry nanoseconds", liveNs, 10);
    wr(2, 30); wr(3, 1); wr(0, 32'h40); idle(1);
    check("R7 step subtract borrow seconds", liveSec, 8);
    check("R7 step subtract borrow nanoseconds", liveNs, 999999980);
  endtask

  task automatic test_swreset();
    wr(0, 32'h1); idle(1);
    check("R12 soft reset seconds", liveSec, 0);
    check("R12 soft reset nanoseconds", liveNs, 0);
  endtask

  task automatic test_speedup();
    wr(4, 32'hBFFF_FFFF);
    wr(0, 32'h6);
    ticks(4);
    check("R8 no carry in first four ticks", liveNs, 160);
    ticks(1);
    check("R8 carry tick adds 41", liveNs, 201);
    wr(0, 32'h0);
  endtask

  task automatic test_slowdown();
    wr(0, 32'h1); idle(1);
    wr(4, 32'h1);
    wr(0, 32'h6);
    ticks(3);
    check("R9 borrow on first tick, R12 accumulator cleared", liveNs, 119);
    wr(0, 32'h1); idle(1);
  endtask

  task automatic test_trim_off();
    logic [31:0] d;
    wr(4, 32'hBFFF_FFFF);
    rd(4, d);
    check("R4 rate register readback", d, 32'hBFFF_FFFF);
    wr(0, 32'h2);
    ticks(5);
    check("R10 trim disabled gives 40 per tick", liveNs, 200);
  endtask

  task automatic test_phase();
    logic [31:0] d;
    idle(10);
    wr(0, 32'h12);
    idle(1);
    rd(1, d);
    check("R11 phase saturates at 4", d, 4);
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    busWe = 1'b1; busAddr = 3'd0; busWdata = 32'h12;
    @(negedge clk); busWe = 1'b0;
    @(negedge clk);
    rd(1, d);
    check("R11 phase one cycle after tick", d, 1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    test_reset();
    test_plain_tick();
    test_load();
    test_wrap();
    test_latch();
    test_step();
    test_swreset();
    test_speedup();
    test_slowdown();
    test_trim_off();
    test_phase();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule